// File: doc/BRIEF.md
# Extended right-shift execute unit

This block executes one instruction of a 32-bit fixed-point core. It examines each 32-bit instruction word and accepts only the extended right-shift operation, in either its plain form or its recording form. For an accepted word it rotates the first source operand right by a 5-bit amount taken from the second operand. The rotated word goes, unchanged, into an internal multiply-quotient (MQ) register. The same word, with the vacated upper bits cleared, goes to the register-file write port.

In the recording form the unit also refreshes a 4-bit condition field from the sign of the written value and from a summary-overflow flag. The surrounding pipeline presents the instruction word and its two operands together with `in_valid`. It reads the register indices from `src_sel` and `amt_sel`. One cycle later it receives a registered write request, or an `illegal` flag if the word did not decode.

Top module: `srx_exec_unit`

## Requirements
- R1: Bits are numbered 0 (MSB, `insn[31]`) to 31 (LSB, `insn[0]`). A word is accepted only when `insn[31:26]` equals 31 and `insn[10:1]` equals 665. The register fields are: source `insn[25:21]` (shown on `src_sel`), target `insn[20:16]`, amount register `insn[15:11]` (shown on `amt_sel`), and record bit `insn[0]`.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and low otherwise.
- R3: For an accepted word, the next cycle has `wr_en`=1, `wr_addr`=`insn[20:16]` and `wr_data` = `src_val` logically shifted right by N. N is `amt_val[4:0]`, and bits 31:5 of `amt_val` have no effect.
- R4: For an accepted word, `mq` takes `src_val` rotated right by N in the next cycle. Example: 0xB0043000 with N=15 gives MQ 0x60016008 and a write value of 0x00016008.
- R5: With N=0, `wr_data` and `mq` both equal `src_val` unchanged.
- R6: For an accepted word with record bit 1, `cond` becomes {LT,GT,EQ,SO} (LT at bit 3) in the next cycle, and `cond_we` pulses for that cycle. LT, GT and EQ compare `wr_data` as a signed value against zero, and SO copies `so_in`.
- R7: For an accepted word with record bit 0, and whenever no word is accepted, `cond` holds its value and `cond_we` stays 0.
- R8: A word that is not accepted gives `illegal`=1 with `out_valid`. In that cycle `wr_en` is 0, and `mq` and `cond` keep their values.
- R9: While `rst_n` is low, `out_valid`, `illegal`, `wr_en`, `cond_we`, `wr_addr`, `wr_data`, `mq` and `cond` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word and operands present |
| insn | input | 32 | Instruction word |
| src_val | input | 32 | Value of the source register |
| amt_val | input | 32 | Value of the amount register |
| so_in | input | 1 | Current summary-overflow flag |
| src_sel | output | 5 | Source register index for the register-file read |
| amt_sel | output | 5 | Amount register index for the register-file read |
| out_valid | output | 1 | Result cycle strobe |
| illegal | output | 1 | The word in the previous cycle did not decode |
| wr_en | output | 1 | Register-file write enable |
| wr_addr | output | 5 | Register-file write index |
| wr_data | output | 32 | Shifted value to write |
| mq | output | 32 | MQ register contents |
| cond_we | output | 1 | Condition field was refreshed this cycle |
| cond | output | 4 | Condition field {LT,GT,EQ,SO} |

## Verification
The shifted result can only be negative when N is 0 and the source is negative, so the LT code is never reached by a random shift amount. EQ is reached only when every source bit above position N is clear. The stimulus therefore includes directed words with N forced to 0 and a negative source, and with a source masked so that only its low N bits survive. Junk is placed in the upper amount bits throughout. A recording word is followed by plain and illegal words, so that the held condition field is observed after each.

// File: rtl/srx_exec_unit.sv
module srx_exec_unit #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [31:0]  insn,
  input  logic [W-1:0] src_val,
  input  logic [W-1:0] amt_val,
  input  logic         so_in,
  output logic [4:0]   src_sel,
  output logic [4:0]   amt_sel,
  output logic         out_valid,
  output logic         illegal,
  output logic         wr_en,
  output logic [4:0]   wr_addr,
  output logic [W-1:0] wr_data,
  output logic [W-1:0] mq,
  output logic         cond_we,
  output logic [3:0]   cond
);
  localparam int unsigned SW = $clog2(W);

  logic          hit, rec;
  logic [SW-1:0] amt;
  logic [W-1:0]  rot, keep, res;
  logic [2*W-1:0] dbl;

  assign hit     = (insn[31:26] == 6'd31) && (insn[10:1] == 10'd665);
  assign rec     = insn[0];
  assign src_sel = insn[25:21];
  assign amt_sel = insn[15:11];
  assign amt     = SW'(amt_val % W);

  assign dbl  = {src_val, src_val} >> amt;
  assign rot  = dbl[W-1:0];
  assign keep = {W{1'b1}} >> amt;
  assign res  = rot & keep;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      mq        <= '0;
      cond_we   <= 1'b0;
      cond      <= '0;
    end else begin
      out_valid <= in_valid;
      illegal   <= in_valid && !hit;
      wr_en     <= in_valid && hit;
      cond_we   <= in_valid && hit && rec;
      if (in_valid && hit) begin
        wr_addr <= insn[20:16];
        wr_data <= res;
        mq      <= rot;
        if (rec)
          cond <= {res[W-1], !res[W-1] && (res != '0), res == '0, so_in};
      end
    end
  end
endmodule

module srx_exec_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [31:0]  insn,
  input logic [W-1:0] src_val,
  input logic [W-1:0] amt_val,
  input logic         out_valid,
  input logic         illegal,
  input logic         wr_en,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] mq,
  input logic         cond_we,
  input logic [3:0]   cond
);
  logic       ok;
  logic [4:0] n;
  logic [5:0] back;
  assign ok   = insn[31:26] == 6'd31 && insn[10:1] == 10'd665;
  assign n    = amt_val[4:0];
  assign back = 6'd32 - {1'b0, n};

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_SHIFT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ok) |=> (wr_en && wr_data == ($past(src_val) >> $past(n)))); // R3
  AST_MQ_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ok) |=> mq == (($past(src_val) >> $past(n)) | ($past(src_val) << $past(back)))); // R4
  AST_COND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && ok && insn[0]) |=> ($stable(cond) && !cond_we)); // R7
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !ok) |=> (illegal && !wr_en && $stable(mq))); // R8
  AST_ILLEGAL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({illegal, wr_en})); // R8
endmodule

bind srx_exec_unit srx_exec_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
  .src_val(src_val), .amt_val(amt_val), .out_valid(out_valid),
  .illegal(illegal), .wr_en(wr_en), .wr_data(wr_data), .mq(mq),
  .cond_we(cond_we), .cond(cond)
);

// File: tb/srx_exec_unit_tb.sv
module srx_exec_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] insn = '0, src_val = '0, amt_val = '0;
  logic so_in = 1'b0;
  logic [4:0] src_sel, amt_sel, wr_addr;
  logic out_valid, illegal, wr_en, cond_we;
  logic [31:0] wr_data, mq;
  logic [3:0] cond;

  int n_run = 0, n_fail = 0;
  logic [31:0] e_mq = '0;
  logic [3:0]  e_cond = '0;

  always #5 clk = ~clk;

  srx_exec_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
    .src_val(src_val), .amt_val(amt_val), .so_in(so_in),
    .src_sel(src_sel), .amt_sel(amt_sel), .out_valid(out_valid),
    .illegal(illegal), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mq(mq), .cond_we(cond_we), .cond(cond)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(logic [4:0] s, logic [4:0] t, logic [4:0] a, logic rc);
    return {6'd31, s, t, a, 10'd665, rc};
  endfunction

  task automatic step(logic v, logic [31:0] w, logic [31:0] s, logic [31:0] a, logic so);
    logic [31:0] rot, res;
    logic good, rc;
    int sh;
    @(negedge clk);
    in_valid = v; insn = w; src_val = s; amt_val = a; so_in = so;
    #1;
    chk("R1 src_sel", 32'(src_sel), 32'(w[25:21]));
    chk("R1 amt_sel", 32'(amt_sel), 32'(w[15:11]));
    good = (w[31:26] == 6'd31) && (w[10:1] == 10'd665);
    rc = w[0];
    sh = int'(a & 32'd31);
    for (int i = 0; i < 32; i++) begin
      rot[i] = s[(i + sh) % 32];
      res[i] = (i < 32 - sh) ? rot[i] : 1'b0;
    end
    @(posedge clk); #2;
    chk("R2 out_valid", 32'(out_valid), 32'(v));
    chk("R8 illegal", 32'(illegal), 32'(v && !good));
    chk("R3 wr_en", 32'(wr_en), 32'(v && good));
    chk("R6/R7 cond_we", 32'(cond_we), 32'(v && good && rc));
    if (v && good) begin
      e_mq = rot;
      if (rc)
        e_cond = {$signed(res) < 0, $signed(res) > 0, res == 0, so};
      chk("R3 wr_addr", 32'(wr_addr), 32'(w[20:16]));
      chk("R3 wr_data", wr_data, res);
    end
    chk("R4 mq", mq, e_mq);
    chk("R6/R7 cond", 32'(cond), 32'(e_cond));
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R9 out_valid", 32'(out_valid), 0);
    chk("R9 wr_en", 32'(wr_en), 0);
    chk("R9 wr_data", wr_data, 0);
    chk("R9 mq", mq, 0);
    chk("R9 cond", 32'(cond), 0);
    @(negedge clk) rst_n = 1'b1;
    step(0, '0, '0, '0, 0);
    // R3 R4 worked value, plain form
    step(1, mk(5'd4, 5'd6, 5'd5, 0), 32'h90003000, 32'h0000000C, 0);
    chk("R3 example ra", wr_data, 32'h00090003);
    // R4 R6 worked value, record form
    step(1, mk(5'd4, 5'd6, 5'd5, 1), 32'hB0043000, 32'h0000000F, 0);
    chk("R4 example mq", mq, 32'h60016008);
    chk("R6 example cond", 32'(cond), 32'h4);
    // R7 plain form keeps cond
    step(1, mk(5'd1, 5'd2, 5'd3, 0), 32'h12345678, 32'hFFFFFFE3, 1);
    // R5 R6 N=0 negative source gives LT, upper amount bits junk
    step(1, mk(5'd7, 5'd8, 5'd9, 1), 32'h80000001, 32'hABCDEF20, 1);
    chk("R5 n0 data", wr_data, 32'h80000001);
    chk("R6 lt cond", 32'(cond), 32'h9);
    // R6 EQ case
    step(1, mk(5'd3, 5'd31, 5'd0, 1), 32'h0000FFFF, 32'h00000010, 0);
    chk("R6 eq cond", 32'(cond), 32'h2);
    // R8 bad primary and bad extended fields
    step(1, mk(5'd3, 5'd4, 5'd5, 1) ^ 32'h04000000, 32'hFFFFFFFF, 32'h1, 1);
    step(1, mk(5'd3, 5'd4, 5'd5, 1) ^ 32'h00000002, 32'hFFFFFFFF, 32'h1, 1);
    chk("R8 cond kept", 32'(cond), 32'h2);
    step(0, mk(5'd3, 5'd4, 5'd5, 1), 32'h1, 32'h1, 1);
    for (int k = 0; k < 300; k++) begin
      logic [31:0] w;
      w = mk(5'($urandom), 5'($urandom), 5'($urandom), 1'($urandom));
      if ($urandom % 5 == 0) w = w ^ (32'd1 << ($urandom % 32));
      step(($urandom % 4) != 0, w, $urandom, $urandom, 1'($urandom));
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule